// File: doc/BRIEF.md
# Prescaled Timer/Counter with Match and Capture Channels

This block is a 32-bit free-running timer/counter with a word-addressed register port. A prescale counter divides the clock before it reaches the main count, and a mode field lets the main count follow edges of one chosen external input instead. Four compare channels watch the count. On a hit, each can flag an interrupt, restart the count from zero or halt it. Each can also drive its own output pin high, low or to the opposite level.

Four capture channels share the same external inputs. Each one copies the count into its own register when its input makes the edge chosen for that channel, and it can flag an interrupt when it does. All external inputs pass through a two-stage synchronizer before their edges are detected. The counter runs in one of three operating states, decoded from the control bits: HELD (the clear bit is set, and both counters are forced to zero), IDLE (the enable bit is clear, and the counters keep their values) and RUN (the counter ticks from its selected source). The transitions are named ENABLE (IDLE to RUN), HALT (RUN to IDLE, by software or by a stop action on a compare hit), CLEAR (any state to HELD) and RELEASE (HELD to IDLE or RUN).

Top module: `tmc_top`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `match_out` is zero.
- R2: Register offsets are as follows. 0x00 flags, 0x04 control, 0x08 count, 0x0C prescale, 0x10 prescale counter, 0x14 compare control, 0x18/0x1C/0x20/0x24 compare values 0 to 3, 0x28 capture control, 0x2C/0x30/0x34/0x38 capture values 0 to 3, 0x3C output control, 0x70 count mode. The count, prescale counter, prescale, compare, control and mode registers read back what was written.
- R3: In timer mode (mode 0) with the enable bit (control bit 0) set, the prescale counter advances on every clock. On a clock where it is at or above the prescale value, it returns to zero and the count advances by one instead. After K enabled clocks from zero, the count is K/(P+1) and the prescale counter is K mod (P+1).
- R4: While the clear bit (control bit 1) is set, the count and the prescale counter are held at zero, whatever else is written.
- R5: If compare control bit 3n+1 is set, a tick that finds the count equal to compare value n loads zero instead of incrementing. The count then runs through 0..M.
- R6: If compare control bit 3n+2 is set, a tick that finds the count equal to compare value n clears the enable bit and leaves the count at that value.
- R7: If compare control bit 3n is set, a compare hit on channel n sets flag bit n. A capture on channel n with capture control bit 3n+2 set sets flag bit n+4. `irq` is high while any flag bit is set.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: The output control register holds the pin levels in bits 3:0 and a 2-bit action per channel at bits 4+2n+1:4+2n. On a hit of channel n, action 0 keeps the level, 1 drives it low, 2 drives it high and 3 inverts it. `match_out` shows bits 3:0.
- R10: Capture control bit 3n enables capture on a rising edge of `ext_in[n]` and bit 3n+1 enables capture on a falling edge. A capture copies the count into capture value n. A channel with neither bit set, or an edge whose bit is clear, leaves the capture value unchanged.
- R11: Count mode bits 1:0 select the tick source: 1 for rising edges, 2 for falling edges, 3 for both. Bits 3:2 select which `ext_in` bit is counted. Edges on any other input do not move the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ext_in | input | 4 | External inputs for capture and edge counting |
| match_out | output | 4 | Compare-driven output pins |
| irq | output | 1 | OR of all flag bits |

## Verification
The bench sweeps the prescale value over 0..3 and the compare value over 0..3. For each pair it works out the count and the prescale counter with integer division and remainder. An off-by-one in the wrap compare, or a wrap that is taken one tick late, shows up as a wrong quotient. It runs every output action from both starting levels, so a swapped set/clear encoding or a toggle that does nothing gives the wrong pin. It counts edges on a selected input while a neighbouring input toggles, and it captures on enabled and disabled edges. A design that counts the wrong input, counts both edges in a single-edge mode, or captures on the wrong edge ends with a wrong count or capture value. It also writes zeros to the flag register to check that a clear happens only where a 1 is written.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam int OFS_FLAGS  = 'h00;
    localparam int OFS_CTRL   = 'h04;
    localparam int OFS_COUNT  = 'h08;
    localparam int OFS_PSCALE = 'h0C;
    localparam int OFS_PSCNT  = 'h10;
    localparam int OFS_MCTL   = 'h14;
    localparam int OFS_MVAL0  = 'h18;
    localparam int OFS_CCTL   = 'h28;
    localparam int OFS_CVAL0  = 'h2C;
    localparam int OFS_XOUT   = 'h3C;
    localparam int OFS_CMODE  = 'h70;

    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        XA_KEEP   = 2'd0,
        XA_LOW    = 2'd1,
        XA_HIGH   = 2'd2,
        XA_INVERT = 2'd3
    } xout_act_e;

    typedef enum logic [1:0] {
        RS_HELD,
        RS_IDLE,
        RS_RUN
    } run_state_e;
endpackage

// File: rtl/tmc_edge.sv
module tmc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [2:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[1:0], din};
    end

    assign rise = stage_q[1] & ~stage_q[2];
    assign fall = ~stage_q[1] & stage_q[2];
endmodule

// File: rtl/tmc_xout.sv
module tmc_xout (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hit,
    input  tmc_pkg::xout_act_e     act,
    input  logic                   sw_wr,
    input  logic                   sw_bit,
    output logic                   level
);
    import tmc_pkg::*;

    logic level_d;

    always_comb begin
        level_d = level;
        if (hit) begin
            unique case (act)
                XA_KEEP:   level_d = level;
                XA_LOW:    level_d = 1'b0;
                XA_HIGH:   level_d = 1'b1;
                XA_INVERT: level_d = ~level;
            endcase
        end else if (sw_wr) begin
            level_d = sw_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level <= 1'b0;
        else        level <= level_d;
    end
endmodule

// File: rtl/tmc_counter.sv
module tmc_counter #(
    parameter int TW  = 32,
    parameter int NCH = 4,
    localparam int SW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     hold,
    input  tmc_pkg::cnt_mode_e       mode,
    input  logic [SW-1:0]            src_sel,
    input  logic [NCH-1:0]           in_rise,
    input  logic [NCH-1:0]           in_fall,
    input  logic [TW-1:0]            pscale,
    input  logic                     wr_count,
    input  logic                     wr_pscnt,
    input  logic [TW-1:0]            wdata,
    input  logic [NCH-1:0][TW-1:0]   mval,
    input  logic [NCH-1:0]           rst_mask,
    input  logic [NCH-1:0]           stop_mask,
    output logic [TW-1:0]            count,
    output logic [TW-1:0]            pscnt,
    output logic [NCH-1:0]           match_evt,
    output logic                     stop_req
);
    import tmc_pkg::*;

    run_state_e    state;
    logic          tick;
    logic          wrap;
    logic          any_rst;
    logic [TW-1:0] count_d;
    logic [TW-1:0] pscnt_d;

    always_comb begin
        if (hold)        state = RS_HELD;
        else if (run_en) state = RS_RUN;
        else             state = RS_IDLE;
    end

    assign wrap = (pscnt >= pscale);

    always_comb begin
        tick = 1'b0;
        unique case (state)
            RS_HELD: tick = 1'b0;
            RS_IDLE: tick = 1'b0;
            RS_RUN: begin
                unique case (mode)
                    SRC_PCLK: tick = wrap;
                    SRC_RISE: tick = in_rise[src_sel];
                    SRC_FALL: tick = in_fall[src_sel];
                    SRC_BOTH: tick = in_rise[src_sel] | in_fall[src_sel];
                endcase
            end
            default: tick = 1'b0;
        endcase
    end

    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        assign match_evt[k] = tick && (count == mval[k]);
    end

    assign any_rst  = |(match_evt & rst_mask);
    assign stop_req = |(match_evt & stop_mask);

    always_comb begin
        count_d = count;
        pscnt_d = pscnt;
        unique case (state)
            RS_HELD: begin
                count_d = '0;
                pscnt_d = '0;
            end
            RS_IDLE, RS_RUN: begin
                if (state == RS_RUN) begin
                    if (mode == SRC_PCLK) pscnt_d = wrap ? '0 : pscnt + 1'b1;
                    else                  pscnt_d = '0;
                end
                if (wr_pscnt) pscnt_d = wdata;
                if (tick) begin
                    if (any_rst)       count_d = '0;
                    else if (stop_req) count_d = count;
                    else               count_d = count + 1'b1;
                end
                if (wr_count) count_d = wdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            pscnt <= '0;
        end else begin
            count <= count_d;
            pscnt <= pscnt_d;
        end
    end

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0) && (pscnt == '0)); // R4
    AST_COUNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_count && !hold) |=> $stable(count)); // R3
endmodule

// File: rtl/tmc_top.sv
module tmc_top #(
    parameter int TW  = 32,
    parameter int NCH = 4,
    parameter int AW  = 7,
    localparam int SW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [TW-1:0]  bus_wdata,
    output logic [TW-1:0]  bus_rdata,
    input  logic [NCH-1:0] ext_in,
    output logic [NCH-1:0] match_out,
    output logic           irq
);
    import tmc_pkg::*;

    logic                   en_q, hold_q;
    logic [TW-1:0]          pscale_q;
    logic [3*NCH-1:0]       mctl_q, cctl_q;
    logic [NCH-1:0][TW-1:0] mval_q, cval_q;
    logic [2*NCH-1:0]       xact_q;
    logic [2*NCH-1:0]       flags_q;
    logic [SW+1:0]          cmode_q;

    logic [NCH-1:0] rise, fall, match_evt, cap_evt;
    logic [NCH-1:0] m_int, m_rst, m_stop, c_int;
    logic [TW-1:0]  count, pscnt;
    logic           stop_req;

    logic wr_flags, wr_ctrl, wr_count, wr_pscale, wr_pscnt;
    logic wr_mctl, wr_cctl, wr_xout, wr_cmode;
    logic [NCH-1:0] wr_mval;

    assign wr_flags  = bus_we && (bus_addr == AW'(OFS_FLAGS));
    assign wr_ctrl   = bus_we && (bus_addr == AW'(OFS_CTRL));
    assign wr_count  = bus_we && (bus_addr == AW'(OFS_COUNT));
    assign wr_pscale = bus_we && (bus_addr == AW'(OFS_PSCALE));
    assign wr_pscnt  = bus_we && (bus_addr == AW'(OFS_PSCNT));
    assign wr_mctl   = bus_we && (bus_addr == AW'(OFS_MCTL));
    assign wr_cctl   = bus_we && (bus_addr == AW'(OFS_CCTL));
    assign wr_xout   = bus_we && (bus_addr == AW'(OFS_XOUT));
    assign wr_cmode  = bus_we && (bus_addr == AW'(OFS_CMODE));

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign wr_mval[k] = bus_we && (bus_addr == AW'(OFS_MVAL0 + 4 * k));
        assign m_int[k]   = mctl_q[3*k];
        assign m_rst[k]   = mctl_q[3*k+1];
        assign m_stop[k]  = mctl_q[3*k+2];
        assign c_int[k]   = cctl_q[3*k+2];
        assign cap_evt[k] = (cctl_q[3*k] & rise[k]) | (cctl_q[3*k+1] & fall[k]);

        tmc_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ext_in[k]),
            .rise (rise[k]),
            .fall (fall[k])
        );

        tmc_xout u_xout (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (match_evt[k]),
            .act   (xout_act_e'(xact_q[2*k+1:2*k])),
            .sw_wr (wr_xout),
            .sw_bit(bus_wdata[k]),
            .level (match_out[k])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           mval_q[k] <= '0;
            else if (wr_mval[k])  mval_q[k] <= bus_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cval_q[k] <= '0;
            else if (cap_evt[k])  cval_q[k] <= count;
        end

        AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_evt[k] |=> $stable(cval_q[k])); // R10
    end

    for (genvar i = 0; i < 2 * NCH; i++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !(wr_flags && bus_wdata[i])) |=> flags_q[i]); // R8
    end

    tmc_counter #(.TW(TW), .NCH(NCH)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (en_q),
        .hold     (hold_q),
        .mode     (cnt_mode_e'(cmode_q[1:0])),
        .src_sel  (cmode_q[SW+1:2]),
        .in_rise  (rise),
        .in_fall  (fall),
        .pscale   (pscale_q),
        .wr_count (wr_count),
        .wr_pscnt (wr_pscnt),
        .wdata    (bus_wdata),
        .mval     (mval_q),
        .rst_mask (m_rst),
        .stop_mask(m_stop),
        .count    (count),
        .pscnt    (pscnt),
        .match_evt(match_evt),
        .stop_req (stop_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            hold_q   <= 1'b0;
            pscale_q <= '0;
            mctl_q   <= '0;
            cctl_q   <= '0;
            xact_q   <= '0;
            cmode_q  <= '0;
            flags_q  <= '0;
        end else begin
            if (wr_ctrl)   hold_q   <= bus_wdata[1];
            if (stop_req)  en_q     <= 1'b0;
            else if (wr_ctrl) en_q  <= bus_wdata[0];
            if (wr_pscale) pscale_q <= bus_wdata;
            if (wr_mctl)   mctl_q   <= bus_wdata[3*NCH-1:0];
            if (wr_cctl)   cctl_q   <= bus_wdata[3*NCH-1:0];
            if (wr_xout)   xact_q   <= bus_wdata[NCH+2*NCH-1:NCH];
            if (wr_cmode)  cmode_q  <= bus_wdata[SW+1:0];
            flags_q <= (flags_q & ~(wr_flags ? bus_wdata[2*NCH-1:0] : '0))
                     | {cap_evt & c_int, match_evt & m_int};
        end
    end

    assign irq = |flags_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_FLAGS))  bus_rdata = TW'(flags_q);
        if (bus_addr == AW'(OFS_CTRL))   bus_rdata = TW'({hold_q, en_q});
        if (bus_addr == AW'(OFS_COUNT))  bus_rdata = count;
        if (bus_addr == AW'(OFS_PSCALE)) bus_rdata = pscale_q;
        if (bus_addr == AW'(OFS_PSCNT))  bus_rdata = pscnt;
        if (bus_addr == AW'(OFS_MCTL))   bus_rdata = TW'(mctl_q);
        if (bus_addr == AW'(OFS_CCTL))   bus_rdata = TW'(cctl_q);
        if (bus_addr == AW'(OFS_XOUT))   bus_rdata = TW'({xact_q, match_out});
        if (bus_addr == AW'(OFS_CMODE))  bus_rdata = TW'(cmode_q);
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == AW'(OFS_MVAL0 + 4 * k)) bus_rdata = mval_q[k];
            if (bus_addr == AW'(OFS_CVAL0 + 4 * k)) bus_rdata = cval_q[k];
        end
    end

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !en_q); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_evt & m_int)) |=> irq); // R7
endmodule

// File: tb/tmc_top_tb.sv
`timescale 1ns/1ps
module tmc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ext_in = '0;
    logic [3:0]  match_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
        .match_out(match_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 7'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic restart();
        wr('h04, 32'h2);
        wr('h04, 32'h1);
    endtask

    task automatic pulse(input int i);
        ext_in[i] = 1'b1;
        repeat (4) @(negedge clk);
        ext_in[i] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h04, v); chk("R1 ctrl", v, 0);
        rd('h08, v); chk("R1 count", v, 0);
        rd('h3C, v); chk("R1 xout", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 match_out", {28'b0, match_out}, 0);

        // R2 register map readback
        wr('h0C, 32'hA5A5); rd('h0C, v); chk("R2 pscale", v, 32'hA5A5);
        wr('h24, 32'h1234_5678); rd('h24, v); chk("R2 mval3", v, 32'h1234_5678);
        wr('h70, 32'hB); rd('h70, v); chk("R2 cmode", v, 32'hB);
        wr('h70, 32'h0);
        wr('h24, 32'hFFFF_FFFF);

        // R3 prescale sweep
        for (int p = 0; p < 4; p++) begin
            for (int kk = 0; kk < 2; kk++) begin
                int k;
                k = (kk == 0) ? 7 : 13;
                wr('h0C, 32'(p));
                restart();
                repeat (k) @(posedge clk);
                @(negedge clk);
                rd('h08, v); chk("R3 count", v, 32'(k / (p + 1)));
                rd('h10, v); chk("R3 pscnt", v, 32'(k % (p + 1)));
            end
        end

        // R4 clear bit holds zero
        wr('h0C, 32'h0);
        wr('h04, 32'h3);
        wr('h08, 32'h55);
        repeat (5) @(negedge clk);
        rd('h08, v); chk("R4 count held", v, 0);
        rd('h10, v); chk("R4 pscnt held", v, 0);
        rd('h04, v); chk("R4 ctrl", v, 3);

        // R5 compare reset sweep
        wr('h14, 32'h2);
        for (int m = 0; m < 4; m++) begin
            wr('h18, 32'(m));
            restart();
            repeat (10) @(posedge clk);
            @(negedge clk);
            rd('h08, v); chk("R5 wrap count", v, 32'(10 % (m + 1)));
        end

        // R6 / R7 / R8 stop with interrupt on channel 1
        wr('h00, 32'hFF);
        wr('h14, (32'h1 << 5) | (32'h1 << 3));
        wr('h1C, 32'd5);
        restart();
        repeat (20) @(negedge clk);
        rd('h08, v); chk("R6 count stays", v, 5);
        rd('h04, v); chk("R6 enable cleared", v, 0);
        rd('h00, v); chk("R7 flag ch1", v, 32'h2);
        chk("R7 irq high", {31'b0, irq}, 1);
        wr('h00, 32'h0);
        rd('h00, v); chk("R8 zero write keeps", v, 32'h2);
        wr('h00, 32'h2);
        rd('h00, v); chk("R8 one write clears", v, 0);
        chk("R8 irq low", {31'b0, irq}, 0);

        // R9 output actions on channel 2
        wr('h14, 32'h1 << 8);
        wr('h20, 32'd3);
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 2; s++) begin
                wr('h3C, (32'(a) << 8) | (32'(s) << 2));
                restart();
                repeat (10) @(negedge clk);
                case (a)
                    0: exp = 32'(s);
                    1: exp = 0;
                    2: exp = 1;
                    default: exp = 32'(1 - s);
                endcase
                rd('h3C, v); chk("R9 level", 32'(v[2]), exp);
                chk("R9 pin", 32'(match_out[2]), exp);
            end
        end

        // R11 edge counting on input 2 with noise on input 1
        wr('h14, 32'h0);
        for (int md = 1; md < 4; md++) begin
            wr('h70, 32'(md) | (32'd2 << 2));
            restart();
            for (int n = 0; n < 3; n++) begin
                pulse(2);
                pulse(1);
            end
            repeat (6) @(negedge clk);
            rd('h08, v); chk("R11 edge count", v, (md == 3) ? 6 : 3);
        end

        // R10 capture
        wr('h70, 32'h0);
        wr('h04, 32'h0);
        wr('h00, 32'hFF);
        wr('h28, 32'h5 | (32'h1 << 10));
        wr('h08, 32'd1234);
        pulse(0);
        rd('h2C, v); chk("R10 rise capture", v, 32'd1234);
        rd('h00, v); chk("R7 capture flag", v, 32'h10);
        wr('h08, 32'd777);
        ext_in[3] = 1'b1;
        repeat (6) @(negedge clk);
        rd('h38, v); chk("R10 rise ignored on fall channel", v, 0);
        ext_in[3] = 1'b0;
        repeat (6) @(negedge clk);
        rd('h38, v); chk("R10 fall capture", v, 32'd777);
        rd('h00, v); chk("R7 no flag without enable", v, 32'h10);
        pulse(1);
        rd('h30, v); chk("R10 disabled channel", v, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule